// File: doc/BRIEF.md
# Load-Use Hazard Stall Guard

This block guards the decode stage of a five-stage in-order pipeline against the one case that operand bypassing cannot cover. That case is an instruction that reads a register which a load, one stage ahead, has not yet fetched from memory. The block holds a small model of the front-end latches: the program counter, the fetch/decode latch, the decode/execute latch and a reduced execute/memory latch. It compares the load sitting in decode/execute with the two source register numbers of the instruction in fetch/decode.

On a match the block raises a stall for exactly one cycle. The program counter and the fetch/decode latch keep their contents, so the dependent instruction is decoded again. The decode/execute latch takes an all-zero slot, which is a NOP. The load moves on into the memory stage unchanged. After that single bubble the operand can be bypassed from the write-back side, so the dependent instruction proceeds on the following cycle.

Each instruction enters as a pre-decoded slot. A slot carries an identifying tag, two source register numbers, a destination register number and a control vector. In the control vector, bit 0 means the instruction writes a register and bit 1 means it is a load. All other control bits travel with the slot.

Top module: `ldg_pipe_guard`

## Requirements
- R1: `stall_o` is 1 when the decode/execute slot has control bit 0 (writes a register) and control bit 1 (load) both set, and its destination is nonzero and equal to either source of the fetch/decode slot; the source may be the first or the second.
- R2: A load whose destination is register 0 never raises `stall_o`, even when a decode source is also 0.
- R3: No stall is raised when the decode/execute slot writes the matching register but is not a load (control 2'b01), or is a load that does not write a register (control 2'b10), or when no source matches.
- R4: On a clock edge where `stall_o` is 1, `pc_o` keeps its value; on every other edge out of reset, it advances by `PC_STEP` (default 4).
- R5: On a stalled edge the fetch/decode latch keeps its slot, so `dec_tag_o` is unchanged and the fetch input presented on that edge is discarded.
- R6: On a stalled edge the decode/execute latch loads an all-zero slot: `exe_ctrl_o` and `exe_tag_o` read 0 on the next cycle.
- R7: On a stalled edge the load still advances: `mem_tag_o` on the next cycle equals the `exe_tag_o` value from the stall cycle.
- R8: A stall lasts one cycle; on the following edge the dependent instruction enters decode/execute with its own tag. A new stall follows only if the condition holds again, for example a load that depends on a load and is itself followed by a user of its result.
- R9: While `rst` is 1, `stall_o` is 0; a reset edge sets `pc_o` to 0 and empties all latches to zero slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_tag | input | TAG_W | Tag of the fetched slot |
| in_src1 | input | REG_W | First source register of the fetched slot |
| in_src2 | input | REG_W | Second source register of the fetched slot |
| in_dst | input | REG_W | Destination register of the fetched slot |
| in_ctrl | input | CTRL_W | Control vector (bit 0 writes register, bit 1 load) |
| pc_o | output | PC_W | Program counter |
| dec_tag_o | output | TAG_W | Tag held in the fetch/decode latch |
| dec_src1_o | output | REG_W | First source in the fetch/decode latch |
| dec_src2_o | output | REG_W | Second source in the fetch/decode latch |
| exe_tag_o | output | TAG_W | Tag held in the decode/execute latch |
| exe_src1_o | output | REG_W | First source in the decode/execute latch |
| exe_src2_o | output | REG_W | Second source in the decode/execute latch |
| exe_dst_o | output | REG_W | Destination in the decode/execute latch |
| exe_ctrl_o | output | CTRL_W | Control vector in the decode/execute latch |
| mem_tag_o | output | TAG_W | Tag held in the execute/memory latch |
| mem_ctrl_o | output | CTRL_W | Control vector in the execute/memory latch |
| stall_o | output | 1 | Load-use stall, driven from latch contents only |

## Verification
Suppose a latch captured the wrong slot or the stall compare looked at the wrong field. The fault would show one edge later in the tags: a lost or repeated `dec_tag_o`, a nonzero `exe_ctrl_o` where a bubble belongs, or a `mem_tag_o` that skipped the load. A wrong program-counter enable shows as a step of 0 or 4 at the wrong edge, visible on the cycle right after the stall. The directed sequences therefore check the tags and the counter on the stall cycle and on the two cycles after it, for both source positions and for each case that must not stall.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
  parameter int TAG_W  = 8;
  parameter int REG_W  = 5;
  parameter int CTRL_W = 4;

  // control bit positions decoded by the hazard compare
  localparam int CB_WRITES = 0;
  localparam int CB_LOAD   = 1;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [REG_W-1:0]  src1;
    logic [REG_W-1:0]  src2;
    logic [REG_W-1:0]  dst;
    logic [CTRL_W-1:0] ctrl;
  } slot_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [CTRL_W-1:0] ctrl;
  } mem_slot_t;

  localparam int SLOT_W     = $bits(slot_t);
  localparam int MEM_SLOT_W = $bits(mem_slot_t);
endpackage

// File: rtl/ldg_hazard_detect.sv
module ldg_hazard_detect #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                   rst,
  input  logic                   exe_writes,
  input  logic                   exe_load,
  input  logic [REG_W-1:0]       exe_dst,
  input  logic [NUM_SRC*REG_W-1:0] dec_srcs,
  output logic                   stall
);
  logic [NUM_SRC-1:0] hit;

  // one comparator per decode source operand
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign hit[g] = (dec_srcs[g*REG_W +: REG_W] == exe_dst);
  end

  logic dst_live;
  assign dst_live = (exe_dst != '0);

  always_comb begin
    stall = 1'b0;
    if (!rst && exe_writes && exe_load && dst_live) begin
      stall = |hit;
    end
  end
endmodule

// File: rtl/ldg_pc_reg.sv
module ldg_pc_reg #(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (!hold) begin
      pc <= pc + STEP;
    end
  end
endmodule

// File: rtl/ldg_stage_reg.sv
module ldg_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || bubble) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/ldg_pipe_guard.sv
module ldg_pipe_guard
  import ldg_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic [PC_W-1:0]   pc_o,
  output logic [TAG_W-1:0]  dec_tag_o,
  output logic [REG_W-1:0]  dec_src1_o,
  output logic [REG_W-1:0]  dec_src2_o,
  output logic [TAG_W-1:0]  exe_tag_o,
  output logic [REG_W-1:0]  exe_src1_o,
  output logic [REG_W-1:0]  exe_src2_o,
  output logic [REG_W-1:0]  exe_dst_o,
  output logic [CTRL_W-1:0] exe_ctrl_o,
  output logic [TAG_W-1:0]  mem_tag_o,
  output logic [CTRL_W-1:0] mem_ctrl_o,
  output logic              stall_o
);
  slot_t     fetch_slot, dec_slot, exe_slot;
  mem_slot_t mem_next, mem_slot;
  logic      stall;

  always_comb begin
    fetch_slot.tag  = in_tag;
    fetch_slot.src1 = in_src1;
    fetch_slot.src2 = in_src2;
    fetch_slot.dst  = in_dst;
    fetch_slot.ctrl = in_ctrl;
    mem_next.tag    = exe_slot.tag;
    mem_next.ctrl   = exe_slot.ctrl;
  end

  ldg_hazard_detect #(.REG_W(REG_W), .NUM_SRC(2)) u_detect (
    .rst        (rst),
    .exe_writes (exe_slot.ctrl[CB_WRITES]),
    .exe_load   (exe_slot.ctrl[CB_LOAD]),
    .exe_dst    (exe_slot.dst),
    .dec_srcs   ({dec_slot.src2, dec_slot.src1}),
    .stall      (stall)
  );

  ldg_pc_reg #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .hold (stall),
    .pc   (pc_o)
  );

  // fetch/decode latch: frozen while stalled
  ldg_stage_reg #(.W(SLOT_W)) u_if_id (
    .clk    (clk),
    .rst    (rst),
    .en     (!stall),
    .bubble (1'b0),
    .d      (fetch_slot),
    .q      (dec_slot)
  );

  // decode/execute latch: takes a zero slot while stalled
  ldg_stage_reg #(.W(SLOT_W)) u_id_ex (
    .clk    (clk),
    .rst    (rst),
    .en     (1'b1),
    .bubble (stall),
    .d      (dec_slot),
    .q      (exe_slot)
  );

  // execute/memory latch: always advances
  ldg_stage_reg #(.W(MEM_SLOT_W)) u_ex_mem (
    .clk    (clk),
    .rst    (rst),
    .en     (1'b1),
    .bubble (1'b0),
    .d      (mem_next),
    .q      (mem_slot)
  );

  assign dec_tag_o  = dec_slot.tag;
  assign dec_src1_o = dec_slot.src1;
  assign dec_src2_o = dec_slot.src2;
  assign exe_tag_o  = exe_slot.tag;
  assign exe_src1_o = exe_slot.src1;
  assign exe_src2_o = exe_slot.src2;
  assign exe_dst_o  = exe_slot.dst;
  assign exe_ctrl_o = exe_slot.ctrl;
  assign mem_tag_o  = mem_slot.tag;
  assign mem_ctrl_o = mem_slot.ctrl;
  assign stall_o    = stall;
endmodule

// File: rtl/ldg_checker.sv
module ldg_checker
  import ldg_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_o,
  input logic [PC_W-1:0]   pc_o,
  input logic [TAG_W-1:0]  dec_tag_o,
  input logic [REG_W-1:0]  dec_src1_o,
  input logic [REG_W-1:0]  dec_src2_o,
  input logic [TAG_W-1:0]  exe_tag_o,
  input logic [REG_W-1:0]  exe_dst_o,
  input logic [CTRL_W-1:0] exe_ctrl_o,
  input logic [TAG_W-1:0]  mem_tag_o
);
  AST_STALL_NEEDS_LOAD_MATCH: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> (exe_ctrl_o[CB_WRITES] && exe_ctrl_o[CB_LOAD] &&
                 (exe_dst_o == dec_src1_o || exe_dst_o == dec_src2_o))); // R1
  AST_NO_ZERO_DST_STALL: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> (exe_dst_o != '0)); // R2
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (pc_o == $past(pc_o))); // R4
  AST_PC_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    !stall_o |=> ((pc_o - $past(pc_o)) == PC_W'(PC_STEP))); // R4
  AST_DECODE_HELD: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (dec_tag_o == $past(dec_tag_o))); // R5
  AST_BUBBLE_INSERTED: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (exe_ctrl_o == '0)); // R6
  AST_LOAD_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (mem_tag_o == $past(exe_tag_o))); // R7
  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> !stall_o); // R8

  always_ff @(posedge clk) begin
    if (rst) begin
      AST_QUIET_IN_RESET: assert (!stall_o); // R9
    end
  end
endmodule

bind ldg_pipe_guard ldg_checker #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_ldg_checker (
  .clk        (clk),
  .rst        (rst),
  .stall_o    (stall_o),
  .pc_o       (pc_o),
  .dec_tag_o  (dec_tag_o),
  .dec_src1_o (dec_src1_o),
  .dec_src2_o (dec_src2_o),
  .exe_tag_o  (exe_tag_o),
  .exe_dst_o  (exe_dst_o),
  .exe_ctrl_o (exe_ctrl_o),
  .mem_tag_o  (mem_tag_o)
);

// File: tb/test_ldg_pipe_guard.sv
`timescale 1ns/1ps
module test_ldg_pipe_guard;
  import ldg_pkg::*;

  localparam int PC_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [TAG_W-1:0]  in_tag  = '0;
  logic [REG_W-1:0]  in_src1 = '0;
  logic [REG_W-1:0]  in_src2 = '0;
  logic [REG_W-1:0]  in_dst  = '0;
  logic [CTRL_W-1:0] in_ctrl = '0;
  logic [PC_W-1:0]   pc_o;
  logic [TAG_W-1:0]  dec_tag_o, exe_tag_o, mem_tag_o;
  logic [REG_W-1:0]  dec_src1_o, dec_src2_o, exe_src1_o, exe_src2_o, exe_dst_o;
  logic [CTRL_W-1:0] exe_ctrl_o, mem_ctrl_o;
  logic              stall_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  ldg_pipe_guard #(.PC_W(PC_W), .PC_STEP(4)) i_ldg_pipe_guard (
    .clk(clk), .rst(rst),
    .in_tag(in_tag), .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .in_ctrl(in_ctrl),
    .pc_o(pc_o), .dec_tag_o(dec_tag_o), .dec_src1_o(dec_src1_o), .dec_src2_o(dec_src2_o),
    .exe_tag_o(exe_tag_o), .exe_src1_o(exe_src1_o), .exe_src2_o(exe_src2_o),
    .exe_dst_o(exe_dst_o), .exe_ctrl_o(exe_ctrl_o),
    .mem_tag_o(mem_tag_o), .mem_ctrl_o(mem_ctrl_o), .stall_o(stall_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present a slot and let one edge pass; sample 1 ns after the edge
  task automatic feed(input logic [7:0] t, input logic [4:0] s1, input logic [4:0] s2,
                      input logic [4:0] d, input logic [3:0] c);
    in_tag = t; in_src1 = s1; in_src2 = s2; in_dst = d; in_ctrl = c;
    @(posedge clk); #1;
  endtask

  task automatic flush();
    feed(8'h01, 5'd0, 5'd0, 5'd0, 4'b0000);
    feed(8'h02, 5'd0, 5'd0, 5'd0, 4'b0000);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    chk("R9 stall low in reset", 32'(stall_o), 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R9 pc cleared", pc_o, 0);
    chk("R9 decode empty", 32'(dec_tag_o), 0);
    chk("R9 execute ctrl empty", 32'(exe_ctrl_o), 0);
    chk("R9 memory empty", 32'(mem_tag_o), 0);
    rst = 1'b0;
  endtask

  // load in execute, dependent in decode through source position sel
  task automatic t_load_use(input bit second_src);
    logic [31:0] p;
    flush();
    feed(8'h21, 5'd1, 5'd2, 5'd5, 4'b0011);
    feed(8'h22, second_src ? 5'd9 : 5'd5, second_src ? 5'd5 : 5'd9, 5'd8, 4'b0001);
    chk(second_src ? "R1 stall on src2" : "R1 stall on src1", 32'(stall_o), 1);
    p = pc_o;
    feed(8'h23, 5'd3, 5'd4, 5'd10, 4'b0001);
    chk("R4 pc held", pc_o, p);
    chk("R5 decode held", 32'(dec_tag_o), 32'h22);
    chk("R6 bubble ctrl", 32'(exe_ctrl_o), 0);
    chk("R6 bubble tag", 32'(exe_tag_o), 0);
    chk("R7 load advanced", 32'(mem_tag_o), 32'h21);
    chk("R8 stall one cycle", 32'(stall_o), 0);
    feed(8'h23, 5'd3, 5'd4, 5'd10, 4'b0001);
    chk("R8 dependent proceeds", 32'(exe_tag_o), 32'h22);
    chk("R4 pc advances after", pc_o, p + 4);
    chk("R5 next fetch accepted", 32'(dec_tag_o), 32'h23);
  endtask

  task automatic t_no_stall(input string req, input logic [3:0] c,
                            input logic [4:0] d, input logic [4:0] s1);
    logic [31:0] p;
    flush();
    feed(8'h41, 5'd1, 5'd2, d, c);
    feed(8'h42, s1, s1, 5'd8, 4'b0001);
    chk(req, 32'(stall_o), 0);
    p = pc_o;
    feed(8'h43, 5'd3, 5'd4, 5'd10, 4'b0001);
    chk({req, " flow"}, 32'(exe_tag_o), 32'h42);
    chk("R4 pc steps", pc_o, p + 4);
  endtask

  task automatic t_chain();
    flush();
    feed(8'h31, 5'd1, 5'd2, 5'd5, 4'b0011);
    feed(8'h32, 5'd5, 5'd0, 5'd6, 4'b0011);
    chk("R1 load after load stalls", 32'(stall_o), 1);
    feed(8'h33, 5'd6, 5'd7, 5'd9, 4'b0001);
    chk("R8 bubble clears stall", 32'(stall_o), 0);
    feed(8'h33, 5'd6, 5'd7, 5'd9, 4'b0001);
    chk("R8 second load in execute", 32'(exe_tag_o), 32'h32);
    chk("R8 second stall raised", 32'(stall_o), 1);
    feed(8'h34, 5'd0, 5'd0, 5'd0, 4'b0000);
    chk("R6 second bubble", 32'(exe_ctrl_o), 0);
    chk("R7 second load advanced", 32'(mem_tag_o), 32'h32);
    feed(8'h34, 5'd0, 5'd0, 5'd0, 4'b0000);
    chk("R8 user proceeds", 32'(exe_tag_o), 32'h33);
  endtask

  task automatic t_reset_mid();
    flush();
    feed(8'h51, 5'd1, 5'd2, 5'd5, 4'b0011);
    feed(8'h52, 5'd5, 5'd5, 5'd8, 4'b0001);
    chk("R1 stall before reset", 32'(stall_o), 1);
    rst = 1'b1; #1;
    chk("R9 reset masks stall", 32'(stall_o), 0);
    @(posedge clk); #1;
    chk("R9 pc cleared mid run", pc_o, 0);
    chk("R9 execute emptied", 32'(exe_tag_o), 0);
    chk("R9 decode emptied", 32'(dec_tag_o), 0);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_load_use(1'b0);
    t_load_use(1'b1);
    t_no_stall("R2 zero destination", 4'b0011, 5'd0, 5'd0);
    t_no_stall("R3 writer not load", 4'b0001, 5'd5, 5'd5);
    t_no_stall("R3 load not writing", 4'b0010, 5'd5, 5'd5);
    t_no_stall("R3 no source match", 4'b0011, 5'd5, 5'd6);
    t_no_stall("R3 other ctrl bits only", 4'b1101, 5'd5, 5'd5);
    t_chain();
    t_reset_mid();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule